// File: doc/BRIEF.md
# Auto Power-Down Conversion Sequencer

This block sequences one sample of a converter that sleeps between samples. While asleep it waits for the active-low start input to go low. That falling edge wakes it up and starts a fixed power-up interval. The conversion phase follows the power-up interval and raises the busy output for a fixed number of cycles. When the conversion finishes, the block latches the parallel sample input into its result register. It then pulses a one-cycle valid strobe and goes back to sleep by itself.

The start pulse is meant to be about as wide as the power-up interval. The conversion begins on whichever comes later: the end of the power-up count or the release of the start input. Both durations are parameters given in nanoseconds. They are converted to clock cycles from a clock-frequency parameter. The start input is asynchronous and passes through a synchronizer before its edge is detected. While the block is awake, any activity on the start input is ignored.

Top module: `adc_pd_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block is asleep: awake_o=0, busy_o=0, valid_o=0, result_o=0.
- R2: In the sleep phase, a high-to-low change of start_n wakes the block. awake_o goes high at the SYNC_STAGES-th clock edge after the first edge that samples start_n low. It is still low at the edge before that one.
- R3: The conversion phase starts at the later of two edges. The first is PWRUP_CYC edges after wake-up. The second is SYNC_STAGES edges after the first edge that samples start_n high again. busy_o then stays high for exactly CONV_CYC cycles, with PWRUP_CYC = CLK_MHZ*PWRUP_NS/1000 and CONV_CYC = CLK_MHZ*CONV_NS/1000.
- R4: At the edge where busy_o falls, awake_o also falls, with no command needed.
- R5: valid_o is high for exactly one cycle, namely the first cycle after busy_o falls.
- R6: result_o takes the value of sample_i at the edge that ends the conversion. At all other times it holds its value, whatever sample_i does.
- R7: While busy_o is high, pulses on start_n are ignored. The conversion length does not change, no extra valid_o is produced, and the block sleeps afterwards.
- R8: Once start_n has been released during power-up, pulling it low again before power-up ends does not delay the conversion start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low conversion start, asynchronous |
| sample_i | input | DATA_W | Parallel conversion result to latch |
| busy_o | output | 1 | High during the conversion phase |
| awake_o | output | 1 | High while powered up (power-up or conversion) |
| valid_o | output | 1 | One-cycle strobe when a new result is latched |
| result_o | output | DATA_W | Latched conversion result |

## Verification
The hardest cases to reach from the ports are start-input activity while the block is awake, and in particular a re-assertion that spans the exact edge where power-up ends. At that edge the synchronized level is low again, and only the remembered release lets the conversion proceed. The stimulus computes every start and release edge as a cycle offset from the first edge that samples the pulse. It can therefore place a short release followed by a re-assertion from five cycles before the end of power-up to well into the conversion. It also places a separate pulse in the middle of the busy phase. A pulse held longer than power-up checks the late-release branch.

// File: rtl/adc_pd_seq_pkg.sv
package adc_pd_seq_pkg;

  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_WAKE  = 2'd1,
    PH_CONV  = 2'd2
  } phase_t;

  function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/seq_start_edge.sv
module seq_start_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic level_hi,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d[0] = start_n;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_hi = sync_q[SYNC_STAGES-1];
  assign fall     = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load | ~done;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/seq_result_reg.sv
module seq_result_reg #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] result,
  output logic              strobe
);

  logic [DATA_W-1:0] result_q;
  logic              strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_q <= '0;
    else if (capture) result_q <= sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= capture;
  end

  assign result = result_q;
  assign strobe = strobe_q;

endmodule

// File: rtl/adc_pd_seq.sv
module adc_pd_seq
  import adc_pd_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned PWRUP_NS    = 2000,
  parameter int unsigned CONV_NS     = 8000,
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              awake_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int unsigned PWRUP_CYC = ns_to_cycles(CLK_MHZ, PWRUP_NS);
  localparam int unsigned CONV_CYC  = ns_to_cycles(CLK_MHZ, CONV_NS);
  localparam int unsigned MAX_CYC   = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PWRUP_LOAD = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LOAD  = CNT_W'(CONV_CYC - 1);

  logic             rst_sync_n;
  logic             start_hi;
  logic             start_fall;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             capture;
  phase_t           ph_q, ph_d;
  logic             rel_q, rel_d;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  seq_start_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_n (start_n),
    .level_hi(start_hi),
    .fall    (start_fall)
  );

  seq_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  seq_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .capture(capture),
    .sample (sample_i),
    .result (result_o),
    .strobe (valid_o)
  );

  // Next-state logic: sleep -> wake on start edge, wake -> conv when
  // power-up elapsed and start released (now or earlier), conv -> sleep.
  always_comb begin
    ph_d     = ph_q;
    rel_d    = rel_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (ph_q)
      PH_SLEEP: begin
        if (start_fall) begin
          ph_d     = PH_WAKE;
          rel_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = PWRUP_LOAD;
        end
      end
      PH_WAKE: begin
        if (start_hi) rel_d = 1'b1;
        if (tmr_done && (rel_q || start_hi)) begin
          ph_d     = PH_CONV;
          tmr_load = 1'b1;
          tmr_val  = CONV_LOAD;
        end
      end
      PH_CONV: begin
        if (tmr_done) begin
          ph_d    = PH_SLEEP;
          capture = 1'b1;
        end
      end
      default: ph_d = PH_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q  <= PH_SLEEP;
      rel_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rel_q <= rel_d;
    end
  end

  assign busy_o  = (ph_q == PH_CONV);
  assign awake_o = (ph_q != PH_SLEEP);

endmodule

// File: rtl/adc_pd_seq_chk.sv
module adc_pd_seq_chk #(
  parameter int unsigned PWRUP_CYC = 100,
  parameter int unsigned CONV_CYC  = 400,
  parameter int unsigned DATA_W    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              awake_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);

  localparam int unsigned LEN_W = $clog2(((PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC) + 2) + 1;

  logic [LEN_W-1:0] busy_len;
  logic [LEN_W-1:0] wake_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
      wake_len <= '0;
    end else begin
      busy_len <= busy_o ? busy_len + 1'b1 : '0;
      wake_len <= (awake_o && !busy_o) ? wake_len + 1'b1 : '0;
    end
  end

  AST_BUSY_NEEDS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> awake_o); // R3
  AST_WAKE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (wake_len >= LEN_W'(PWRUP_CYC))); // R3
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len == LEN_W'(CONV_CYC))); // R3
  AST_SLEEP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !awake_o); // R4
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $fell(busy_o)); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o)); // R6

endmodule

bind adc_pd_seq adc_pd_seq_chk #(
  .PWRUP_CYC(PWRUP_CYC),
  .CONV_CYC (CONV_CYC),
  .DATA_W   (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_o  (busy_o),
  .awake_o (awake_o),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/test_adc_pd_seq.sv
module test_adc_pd_seq;

  localparam int CLK_PERIOD = 20;
  localparam int CLK_MHZ    = 50;
  localparam int DATA_W     = 10;
  localparam int SYNC       = 2;
  localparam int P          = CLK_MHZ * 2000 / 1000;
  localparam int C          = CLK_MHZ * 8000 / 1000;

  typedef struct {
    int                cyc;
    logic [DATA_W-1:0] data;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              start_n;
  logic [DATA_W-1:0] sample_i;
  logic              busy_o;
  logic              awake_o;
  logic              valid_o;
  logic [DATA_W-1:0] result_o;

  int   cyc;
  int   checks;
  int   errors;
  int   busy_run;
  logic prev_valid;
  logic mon_on;
  exp_t sb_q[$];

  adc_pd_seq #(.CLK_MHZ(CLK_MHZ), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) i_adc_pd_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .sample_i(sample_i),
    .busy_o  (busy_o),
    .awake_o (awake_o),
    .valid_o (valid_o),
    .result_o(result_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected results as valid strobes appear.
  always @(negedge clk) begin
    if (mon_on) begin
      if (busy_o) busy_run++;
      if (valid_o) begin
        check(!prev_valid, "R5 strobe longer than one cycle", 1, 0);
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected valid strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.cyc, "R3 valid strobe cycle", cyc, e.cyc);
          check(result_o == e.data, "R6 latched result", int'(result_o), int'(e.data));
          check(busy_o == 1'b0 && awake_o == 1'b0, "R4 sleep at end of conversion",
                int'({busy_o, awake_o}), 0);
          check(busy_run == C, "R3 busy length", busy_run, C);
        end
        busy_run = 0;
      end
      prev_valid = valid_o;
    end
  end

  // Driver: one conversion, pulse width w, optional extra low pulse at
  // offset gat (from first low-sampling edge k) lasting glen cycles.
  task automatic convert(input int w, input logic [DATA_W-1:0] d, input int gat, input int glen);
    int k;
    int later;
    exp_t e;
    k = cyc + 1;
    later = (w > P) ? w : P;
    e.cyc  = k + SYNC + later + C;
    e.data = d;
    sb_q.push_back(e);
    sample_i = d;
    start_n  = 1'b0;
    fork
      begin
        repeat (w) @(negedge clk);
        start_n = 1'b1;
        if (glen > 0) begin
          repeat (gat - w) @(negedge clk);
          start_n = 1'b0;
          repeat (glen) @(negedge clk);
          start_n = 1'b1;
        end
      end
      begin
        repeat (SYNC) @(negedge clk);
        check(awake_o == 1'b0, "R2 awake too early", int'(awake_o), 0);
        @(negedge clk);
        check(awake_o == 1'b1, "R2 wake on start edge", int'(awake_o), 1);
        check(busy_o == 1'b0, "R3 busy during power-up", int'(busy_o), 0);
      end
    join
    wait (sb_q.size() == 0);
    repeat (20) @(negedge clk);
    check(awake_o == 1'b0, "R7 block stays asleep", int'(awake_o), 0);
    sample_i = ~d;
    repeat (5) @(negedge clk);
    check(result_o == d, "R6 result holds", int'(result_o), int'(d));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    checks     = 0;
    errors     = 0;
    busy_run   = 0;
    prev_valid = 1'b0;
    mon_on     = 1'b0;
    rst_n      = 1'b0;
    start_n    = 1'b1;
    sample_i   = '0;
    repeat (3) @(negedge clk);
    check(awake_o == 0 && busy_o == 0, "R1 phase in reset", int'({awake_o, busy_o}), 0);
    check(valid_o == 0 && result_o == 0, "R1 outputs in reset", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(awake_o == 0 && busy_o == 0, "R1 phase after reset", int'({awake_o, busy_o}), 0);
    check(valid_o == 0 && result_o == 0, "R1 outputs after reset", int'(result_o), 0);
    mon_on = 1'b1;

    convert(P, 10'h2A5, 0, 0);          // R2 R3 nominal pulse
    convert(5, 10'h3FF, 0, 0);          // R3 short pulse, power-up governs
    convert(P + 60, 10'h000, 0, 0);     // R3 late release governs
    convert(P, 10'h155, P + 150, 10);   // R7 pulse during busy
    convert(5, 10'h0F0, P - 5, 30);     // R8 re-assert across power-up end
    convert(P, 10'h001, 0, 0);

    check(sb_q.size() == 0, "R5 missing strobes", sb_q.size(), 0);
    finish_run();
  end

endmodule